// File: doc/BRIEF.md
# Tree-Walking Prefix Code Decoder

This block turns a serial stream of prefix-free variable-length codewords into symbol indices. The code tree sits in a constant node table given as a parameter. Each node is either a leaf that carries a symbol index, or an internal node that carries two child addresses. Address 0 is the root, so a child address of 0 marks a branch that has no codeword behind it. Each accepted input bit moves the walk one level down the tree. Because no codeword is the prefix of another, reaching a leaf always ends a symbol, and the walk then goes back to the root.

Input bits arrive on a valid/ready pair. Decoded symbols leave on a second valid/ready pair and are held until the consumer takes them. While a symbol waits, no further input is accepted. An input bit that selects a missing branch produces a one-cycle error pulse and sends the walk back to the root. A stride option consumes two bits per beat. In that mode a table with four outcomes per node is derived from the binary tree at elaboration, and a codeword may end on either bit of the pair. The elaboration checks reject a stride other than 1 or 2 and a root that is a leaf. In stride 2 they also reject a root child that is missing or is a leaf, which guarantees at most one symbol per beat.

Top module: `prefix_tree_decoder`

## Requirements
- R1: After reset, sym_valid and path_err are 0 and bit_ready is 1. The walk is at the root, so any partly received codeword is dropped and the next bit starts a new codeword.
- R2: With the default tree and stride 1, the codes 00, 010, 011, 110 and 1110 decode to symbols 0, 1, 2, 3 and 4. The leftmost code bit is received first. sym_valid and sym_idx show the symbol in the cycle after the clock edge that accepts the last code bit.
- R3: Codewords sent back to back with no idle cycles each decode correctly. The bit after a leaf is decoded from the root.
- R4: A bit that selects a missing branch makes path_err 1 for exactly the one cycle after the edge that accepts it. With the default tree this happens on the second bit of 10 and on the fourth bit of 1111. No symbol is emitted for that bit, and the next bit is decoded from the root.
- R5: While sym_valid is 1 and sym_ready is 0, sym_valid and sym_idx hold their values, bit_ready is 0 and no bit is consumed. A bit offered during the stall is consumed exactly once after sym_ready rises.
- R6: Cycles with bit_valid at 0 change nothing, including cycles in the middle of a codeword. They produce no symbol and no error.
- R7: With stride 2, bit_data[1] is the earlier bit of the beat. The default codes decode as in R2. When a codeword ends on bit_data[1], bit_data[0] is decoded from the root in the same beat. The symbol shows in the cycle after the accepting edge.
- R8: With stride 2, a missing branch on either bit of a beat raises path_err for one cycle and discards the whole beat. The next beat is decoded from the root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Input beat present |
| bit_data | input | STRIDE | Code bits of the beat; bit STRIDE-1 is received first |
| bit_ready | output | 1 | Block can accept a beat this cycle |
| sym_valid | output | 1 | Decoded symbol present |
| sym_idx | output | SYM_W | Decoded symbol index |
| sym_ready | input | 1 | Consumer takes the symbol this cycle |
| path_err | output | 1 | One-cycle pulse: the accepted beat selected a missing branch |

## Verification
The only hidden state is the node pointer, so the ports show a pointer that is wrong or is not returned to the root. It appears at the end of the next codeword, at most four bits later with the default tree, as a wrong symbol index or as an error pulse where none is expected. The bench therefore sends codewords back to back, with idle gaps and across error recovery, so that every leaf and every missing branch is reached from a fresh walk. The stall test offers a bit during backpressure and then checks the symbol that completes the codeword. That symbol shows at once whether the offered bit was lost, consumed once, or consumed more than once.

// File: rtl/prefix_tree_pkg.sv
package prefix_tree_pkg;

   localparam int DFLT_SYM_W = 3;
   localparam int DFLT_AW    = 4;
   localparam int DFLT_NODES = 11;
   localparam int DFLT_ENT_W = 1 + DFLT_SYM_W + 2 * DFLT_AW;

   // Node entry layout, LSB first: child-for-1, child-for-0, symbol, leaf flag
   function automatic logic [DFLT_ENT_W-1:0] node_int(input int c0, input int c1);
      return {1'b0, {DFLT_SYM_W{1'b0}}, DFLT_AW'(c0), DFLT_AW'(c1)};
   endfunction

   function automatic logic [DFLT_ENT_W-1:0] node_leaf(input int s);
      return {1'b1, DFLT_SYM_W'(s), {(2 * DFLT_AW){1'b0}}};
   endfunction

   // Default tree: 00->0, 010->1, 011->2, 110->3, 1110->4; 10 and 1111 unused
   localparam logic [DFLT_NODES*DFLT_ENT_W-1:0] DFLT_TREE = {
      node_leaf(4),      // 10
      node_int(10, 0),   // 9  : 111
      node_leaf(3),      // 8
      node_leaf(2),      // 7
      node_leaf(1),      // 6
      node_int(8, 9),    // 5  : 11
      node_int(6, 7),    // 4  : 01
      node_leaf(0),      // 3
      node_int(0, 5),    // 2  : 1
      node_int(3, 4),    // 1  : 0
      node_int(1, 2)     // 0  : root
   };

endpackage

// File: rtl/ptd_tree_rom.sv
module ptd_tree_rom #(
   parameter int SYM_W  = prefix_tree_pkg::DFLT_SYM_W,
   parameter int AW     = prefix_tree_pkg::DFLT_AW,
   parameter int NODES  = prefix_tree_pkg::DFLT_NODES,
   parameter int STRIDE = 1,
   parameter logic [NODES*(1+SYM_W+2*AW)-1:0] TREE = prefix_tree_pkg::DFLT_TREE
) (
   input  logic [AW-1:0]     cur,
   input  logic [STRIDE-1:0] bits,
   output logic              step_err,
   output logic              step_emit,
   output logic [SYM_W-1:0]  step_sym,
   output logic [AW-1:0]     step_nxt,
   output logic              cur_leaf
);

   localparam int ENT_W  = 1 + SYM_W + 2 * AW;
   localparam int RES_W  = 2 + SYM_W + AW;
   localparam int WAYS   = 1 << STRIDE;
   localparam int WIDE_N = NODES * WAYS;

   function automatic logic [ENT_W-1:0] ent(input logic [AW-1:0] a);
      int idx;
      idx = int'(a) * ENT_W;
      if (int'(a) < NODES) return TREE[idx +: ENT_W];
      return '0;
   endfunction

   function automatic logic is_leaf(input logic [AW-1:0] a);
      logic [ENT_W-1:0] e;
      e = ent(a);
      return e[ENT_W-1];
   endfunction

   // Result layout, MSB first: err, emit, symbol, next node
   function automatic logic [RES_W-1:0] walk1(input logic [AW-1:0] a, input logic b);
      logic [ENT_W-1:0] e;
      logic [ENT_W-1:0] ce;
      logic [AW-1:0]    ch;
      logic [RES_W-1:0] r;
      e  = ent(a);
      ch = b ? e[0 +: AW] : e[AW +: AW];
      r  = '0;
      if (e[ENT_W-1] || ch == '0 || int'(ch) >= NODES) begin
         r[RES_W-1] = 1'b1;
      end else begin
         ce = ent(ch);
         if (ce[ENT_W-1]) begin
            r[RES_W-2]      = 1'b1;
            r[AW +: SYM_W]  = ce[2*AW +: SYM_W];
         end else begin
            r[0 +: AW] = ch;
         end
      end
      return r;
   endfunction

   function automatic logic [RES_W-1:0] walk2(input logic [AW-1:0] a, input logic [1:0] p);
      logic [RES_W-1:0] r1;
      logic [RES_W-1:0] r2;
      r1 = walk1(a, p[1]);
      if (r1[RES_W-1]) return r1;
      if (r1[RES_W-2]) begin
         r2 = walk1('0, p[0]);
         r2[RES_W-2]     = 1'b1;
         r2[AW +: SYM_W] = r1[AW +: SYM_W];
         return r2;
      end
      return walk1(r1[0 +: AW], p[0]);
   endfunction

   function automatic logic [WIDE_N*RES_W-1:0] build_wide();
      logic [WIDE_N*RES_W-1:0] w;
      w = '0;
      for (int n = 0; n < NODES; n++) begin
         for (int p = 0; p < WAYS; p++) begin
            w[(n*WAYS + p)*RES_W +: RES_W] = walk2(AW'(n), 2'(p));
         end
      end
      return w;
   endfunction

   localparam logic [RES_W-1:0] ROOT_ON0 = walk1('0, 1'b0);
   localparam logic [RES_W-1:0] ROOT_ON1 = walk1('0, 1'b1);

   initial begin : elab_chk
      if (STRIDE != 1 && STRIDE != 2)
         $fatal(1, "ptd_tree_rom: STRIDE must be 1 or 2");
      if (NODES < 2 || NODES > (1 << AW))
         $fatal(1, "ptd_tree_rom: NODES does not fit the address width");
      if (TREE[ENT_W-1])
         $fatal(1, "ptd_tree_rom: root node must be internal");
      if (STRIDE == 2 && (ROOT_ON0[RES_W-1 -: 2] != 2'b00 || ROOT_ON1[RES_W-1 -: 2] != 2'b00))
         $fatal(1, "ptd_tree_rom: stride 2 needs two internal root children");
   end

   logic [RES_W-1:0] res;

   generate
      if (STRIDE == 1) begin : g_bitwise
         assign res = walk1(cur, bits[0]);
      end else begin : g_pairwise
         localparam logic [WIDE_N*RES_W-1:0] WIDE = build_wide();
         always_comb begin
            res = {1'b1, {(RES_W-1){1'b0}}};
            if (int'(cur) < NODES)
               res = WIDE[(int'(cur)*WAYS + int'(bits))*RES_W +: RES_W];
         end
      end
   endgenerate

   assign step_err  = res[RES_W-1];
   assign step_emit = res[RES_W-2];
   assign step_sym  = res[AW +: SYM_W];
   assign step_nxt  = res[0 +: AW];
   assign cur_leaf  = is_leaf(cur);

endmodule

// File: rtl/ptd_walker.sv
module ptd_walker #(
   parameter int AW = prefix_tree_pkg::DFLT_AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          step_err,
   input  logic [AW-1:0] step_nxt,
   input  logic          cur_leaf,
   output logic [AW-1:0] cur_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cur_q <= '0;
      else if (take)
         cur_q <= step_err ? '0 : step_nxt;
   end

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(cur_q));

   // R4
   err_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && step_err) |=> (cur_q == '0));

   // R3
   node_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_leaf);

endmodule

// File: rtl/ptd_out_stage.sv
module ptd_out_stage #(
   parameter int SYM_W = prefix_tree_pkg::DFLT_SYM_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             step_err,
   input  logic             step_emit,
   input  logic [SYM_W-1:0] step_sym,
   input  logic             sym_ready,
   output logic             can_take,
   output logic             sym_valid,
   output logic [SYM_W-1:0] sym_idx,
   output logic             path_err
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sym_valid <= 1'b0;
         sym_idx   <= '0;
         path_err  <= 1'b0;
      end else begin
         path_err <= take && step_err;
         if (take && step_emit && !step_err) begin
            sym_valid <= 1'b1;
            sym_idx   <= step_sym;
         end else if (sym_ready) begin
            sym_valid <= 1'b0;
         end
      end
   end

   assign can_take = !sym_valid || sym_ready;

   // R5
   sym_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_idx)));

   // R4
   err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      path_err |-> !sym_valid);

endmodule

// File: rtl/prefix_tree_decoder.sv
module prefix_tree_decoder #(
   parameter int SYM_W  = prefix_tree_pkg::DFLT_SYM_W,
   parameter int AW     = prefix_tree_pkg::DFLT_AW,
   parameter int NODES  = prefix_tree_pkg::DFLT_NODES,
   parameter int STRIDE = 1,
   parameter logic [NODES*(1+SYM_W+2*AW)-1:0] TREE = prefix_tree_pkg::DFLT_TREE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_valid,
   input  logic [STRIDE-1:0] bit_data,
   output logic              bit_ready,
   output logic              sym_valid,
   output logic [SYM_W-1:0]  sym_idx,
   input  logic              sym_ready,
   output logic              path_err
);

   logic [AW-1:0]    cur_q;
   logic             step_err;
   logic             step_emit;
   logic [SYM_W-1:0] step_sym;
   logic [AW-1:0]    step_nxt;
   logic             cur_leaf;
   logic             take;

   assign take = bit_valid && bit_ready;

   ptd_tree_rom #(
      .SYM_W (SYM_W),
      .AW    (AW),
      .NODES (NODES),
      .STRIDE(STRIDE),
      .TREE  (TREE)
   ) u_rom (
      .cur      (cur_q),
      .bits     (bit_data),
      .step_err (step_err),
      .step_emit(step_emit),
      .step_sym (step_sym),
      .step_nxt (step_nxt),
      .cur_leaf (cur_leaf)
   );

   ptd_walker #(.AW(AW)) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .step_err(step_err),
      .step_nxt(step_nxt),
      .cur_leaf(cur_leaf),
      .cur_q   (cur_q)
   );

   ptd_out_stage #(.SYM_W(SYM_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .step_err (step_err),
      .step_emit(step_emit),
      .step_sym (step_sym),
      .sym_ready(sym_ready),
      .can_take (bit_ready),
      .sym_valid(sym_valid),
      .sym_idx  (sym_idx),
      .path_err (path_err)
   );

   // R3
   emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && step_emit && !step_err) |=> sym_valid);

endmodule

// File: tb/prefix_tree_decoder_bench.sv
`timescale 1ns/1ps
module prefix_tree_decoder_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   // stride-1 instance
   logic       a_valid = 1'b0, a_data = 1'b0, a_ready, a_sv, a_sr = 1'b1, a_err;
   logic [2:0] a_sym;
   // stride-2 instance
   logic       b_valid = 1'b0, b_ready, b_sv, b_sr = 1'b1, b_err;
   logic [1:0] b_data = 2'b00;
   logic [2:0] b_sym;

   prefix_tree_decoder #(.STRIDE(1)) u_prefix_tree_decoder (
      .clk(clk), .rst_n(rst_n), .bit_valid(a_valid), .bit_data(a_data),
      .bit_ready(a_ready), .sym_valid(a_sv), .sym_idx(a_sym),
      .sym_ready(a_sr), .path_err(a_err));

   prefix_tree_decoder #(.STRIDE(2)) u_prefix_tree_decoder_s2 (
      .clk(clk), .rst_n(rst_n), .bit_valid(b_valid), .bit_data(b_data),
      .bit_ready(b_ready), .sym_valid(b_sv), .sym_idx(b_sym),
      .sym_ready(b_sr), .path_err(b_err));

   int n_tests = 0;
   int n_fail  = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // stride-1 vectors: [11:9] length, [8:5] code bits (first bit at [5+len-1]),
   // [4:3] kind (1 symbol, 2 error), [2:0] symbol
   localparam logic [11:0] S1_VEC [0:7] = '{
      {3'd2, 4'b0000, 2'd1, 3'd0},
      {3'd3, 4'b0010, 2'd1, 3'd1},
      {3'd3, 4'b0011, 2'd1, 3'd2},
      {3'd3, 4'b0110, 2'd1, 3'd3},
      {3'd4, 4'b1110, 2'd1, 3'd4},
      {3'd2, 4'b0010, 2'd2, 3'd0},
      {3'd4, 4'b1111, 2'd2, 3'd0},
      {3'd3, 4'b0011, 2'd1, 3'd2}
   };

   // stride-2 vectors: [6:5] beat (bit 6 first), [4:3] kind (0 none, 1 symbol, 2 error), [2:0] symbol
   localparam logic [6:0] S2_VEC [0:16] = '{
      {2'b01, 2'd0, 3'd0}, {2'b00, 2'd1, 3'd1}, {2'b11, 2'd1, 3'd2},
      {2'b00, 2'd1, 3'd0}, {2'b11, 2'd0, 3'd0}, {2'b01, 2'd1, 3'd3},
      {2'b11, 2'd0, 3'd0}, {2'b00, 2'd1, 3'd4}, {2'b10, 2'd1, 3'd1},
      {2'b10, 2'd2, 3'd0}, {2'b11, 2'd0, 3'd0}, {2'b11, 2'd2, 3'd0},
      {2'b11, 2'd0, 3'd0}, {2'b01, 2'd1, 3'd3}, {2'b00, 2'd2, 3'd0},
      {2'b01, 2'd0, 3'd0}, {2'b10, 2'd1, 3'd2}
   };

   task automatic s1_bit(input logic b, output logic v, output logic [2:0] s, output logic e);
      @(negedge clk);
      a_valid = 1'b1;
      a_data  = b;
      @(posedge clk);
      #1;
      v = a_sv; s = a_sym; e = a_err;
   endtask

   task automatic s2_beat(input logic [1:0] p, output logic v, output logic [2:0] s, output logic e);
      @(negedge clk);
      b_valid = 1'b1;
      b_data  = p;
      @(posedge clk);
      #1;
      v = b_sv; s = b_sym; e = b_err;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin : watchdog
      #200000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

   initial begin : main
      logic v, e, bad;
      logic [2:0] s;

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(a_sv == 1'b0, "R1 sym_valid", a_sv, 0);
      chk(a_err == 1'b0, "R1 path_err", a_err, 0);
      chk(a_ready == 1'b1 && b_ready == 1'b1, "R1 bit_ready", a_ready, 1);

      // R2 R3 R4: stride-1 vectors, back to back
      for (int i = 0; i < 8; i++) begin
         logic [11:0] vec;
         int len;
         vec = S1_VEC[i];
         len = int'(vec[11:9]);
         bad = 1'b0;
         v = 1'b0; e = 1'b0; s = '0;
         for (int k = len - 1; k >= 0; k--) begin
            s1_bit(vec[5+k], v, s, e);
            if (k != 0 && (v || e)) bad = 1'b1;
         end
         if (vec[4:3] == 2'd1)
            chk(!bad && v && !e && s == vec[2:0], "R2 R3 symbol", int'(s), int'(vec[2:0]));
         else
            chk(!bad && e && !v, "R4 error", int'(e), 1);
      end
      @(negedge clk) a_valid = 1'b0;

      // R6: idle cycles inside a codeword
      s1_bit(1'b1, v, s, e);
      @(negedge clk) a_valid = 1'b0;
      bad = 1'b0;
      for (int c = 0; c < 3; c++) begin
         @(posedge clk); #1;
         if (a_sv || a_err) bad = 1'b1;
      end
      chk(!bad && !v && !e, "R6 idle quiet", int'(bad), 0);
      s1_bit(1'b1, v, s, e);
      s1_bit(1'b0, v, s, e);
      chk(v && !e && s == 3'd3, "R6 resume", int'(s), 3);
      @(negedge clk) a_valid = 1'b0;

      // R5: backpressure
      @(negedge clk) a_sr = 1'b0;
      s1_bit(1'b0, v, s, e);
      s1_bit(1'b0, v, s, e);
      chk(v && s == 3'd0, "R5 symbol before stall", int'(s), 0);
      @(negedge clk);
      a_valid = 1'b1;
      a_data  = 1'b0;
      for (int c = 0; c < 3; c++) begin
         @(posedge clk); #1;
         chk(a_sv && a_sym == 3'd0 && !a_ready, "R5 hold", int'(a_sym), 0);
      end
      @(negedge clk) a_sr = 1'b1;
      @(posedge clk); #1;
      chk(!a_sv && !a_err, "R5 release", int'(a_sv), 0);
      s1_bit(1'b1, v, s, e);
      s1_bit(1'b1, v, s, e);
      chk(v && !e && s == 3'd2, "R5 stalled bit once", int'(s), 2);
      @(negedge clk) a_valid = 1'b0;

      // R7 R8: stride-2 vectors
      for (int i = 0; i < 17; i++) begin
         logic [6:0] vec;
         vec = S2_VEC[i];
         s2_beat(vec[6:5], v, s, e);
         case (vec[4:3])
            2'd0:    chk(!v && !e, "R7 no event", int'(v), 0);
            2'd1:    chk(v && !e && s == vec[2:0], "R7 symbol", int'(s), int'(vec[2:0]));
            default: chk(e && !v, "R8 error", int'(e), 1);
         endcase
      end
      @(negedge clk) b_valid = 1'b0;

      // R1: reset in the middle of a codeword
      s1_bit(1'b1, v, s, e);
      s1_bit(1'b1, v, s, e);
      @(negedge clk);
      a_valid = 1'b0;
      rst_n   = 1'b0;
      @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      chk(!a_sv && !a_err && a_ready, "R1 reset mid-word", int'(a_sv), 0);
      s1_bit(1'b0, v, s, e);
      s1_bit(1'b0, v, s, e);
      chk(v && !e && s == 3'd0, "R1 restart from root", int'(s), 0);
      @(negedge clk) a_valid = 1'b0;

      summary();
      $finish;
   end

endmodule